// File: doc/BRIEF.md
# Phase Comparator with Lock Detection

This block compares a divided oscillator pulse train against a reference pulse train and produces up/down controls for a main charge pump. Both inputs are single-cycle strobes that are synchronous to a fast sampling clock. The pulse that arrives first opens an error window. The other pulse closes it. The window's length in clock cycles is the phase error. A two-bit mode picks one of four dead-zone behaviours. Two modes keep both pump sides briefly active after every comparison. The other two modes suppress small errors entirely.

The same error count feeds a lock monitor. When an error exceeds a selectable width, the monitor flags the loop as unlocked. It holds that flag through a retriggerable stretch timer. While the loop is unlocked, a sub charge pump can mirror the main pump so that the loop filter's time constant drops and lock comes faster. A force-low control pulls both pumps to the sinking side. This recovers an oscillator that has stalled at zero tuning voltage.

Pump encoding on each pump pair: only up asserted means drive high, only down asserted means drive low, neither asserted means high impedance, and both asserted means both current sources are on.

Top module: `phase_lock_cmp`

## Requirements
- R1: When the divided pulse leads, only `pump_up_o` carries the lead-side error. When the reference pulse leads, only `pump_dn_o` carries it. Between comparisons both are low (high impedance).
- R2: In the dead-zone modes `dz_mode_i`=2'b10 and 2'b11, the lead side of an error of w cycles is asserted for max(0, w-DZC_CYC) cycles or max(0, w-DZD_CYC) cycles respectively, and the other side stays low.
- R3: In the modes `dz_mode_i`=2'b00 and 2'b01, the lead side is asserted for the w cycles of the error. Both sides are then asserted together for MIN_A_CYC or MIN_B_CYC cycles respectively after every comparison, including a comparison with zero error (coincident pulses).
- R4: `ul_sel_i`=2'b00 disables detection and keeps `unlock_o` low whatever the error. 2'b01 selects the threshold UL_NARROW_CYC. 2'b10 and 2'b11 select UL_WIDE_CYC. An error of w cycles marks the loop unlocked only when w exceeds the threshold.
- R5: `unlock_o` rises one cycle after the error exceeds the threshold. It stays high for STRETCH_CYC cycles after the last oversized error cycle, retriggering while the error lasts, so the total is w-th-1+STRETCH_CYC cycles.
- R6: `sub_ctl_i`=2'b00 or 2'b01 keeps the sub pump at high impedance. 2'b10 makes the sub pump mirror the main pump only while `unlock_o` is high. 2'b11 makes it mirror the main pump always.
- R7: While `force_low_i` is high, both pumps drive low (down asserted, up deasserted) in every mode.
- R8: During reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference pulse strobe |
| div_i | input | 1 | Divided oscillator pulse strobe |
| dz_mode_i | input | 2 | Dead-zone mode (00,01 both-on; 10,11 suppressed) |
| ul_sel_i | input | 2 | Unlock width select (00 off, 01 narrow, 1x wide) |
| sub_ctl_i | input | 2 | Sub pump control (0x off, 10 while unlocked, 11 always) |
| force_low_i | input | 1 | Force both pumps low |
| pump_up_o | output | 1 | Main pump source enable |
| pump_dn_o | output | 1 | Main pump sink enable |
| sub_up_o | output | 1 | Sub pump source enable |
| sub_dn_o | output | 1 | Sub pump sink enable |
| unlock_o | output | 1 | Unlocked indication (1 = indication pin pulled low) |

## Verification
The bench sweeps errors from zero to well beyond the wide threshold, with either pulse leading, in all four dead-zone modes. The unlock width and sub pump settings rotate across the runs. Coincident pulses separate the correction pulse of the both-on modes from the silence of the suppressed modes. Errors just below, at and just above each dead-zone count and each unlock threshold separate the strict inequalities from off-by-one variants. Each run integrates the cycles of every output over a window that covers the full stretch. The integrated counts expose the stretch length, the side polarity and any sub pump activity that is wrongly gated by the unlock flag.

// File: rtl/phase_lock_pkg.sv
`timescale 1ns/1ps
package phase_lock_pkg;
  typedef enum logic [1:0] {
    DZ_A = 2'b00,
    DZ_B = 2'b01,
    DZ_C = 2'b10,
    DZ_D = 2'b11
  } dz_mode_e;
endpackage

// File: rtl/phase_err_track.sv
`timescale 1ns/1ps
module phase_err_track #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_i,
  input  logic          div_i,
  output logic          lead_up_o,
  output logic          lead_dn_o,
  output logic [CW-1:0] err_cnt_o,
  output logic          close_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          up_q, dn_q;
  logic [CW-1:0] cnt_q;
  logic          idle;

  assign idle    = !up_q && !dn_q;
  assign close_o = (idle && ref_i && div_i) || (up_q && ref_i) || (dn_q && div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else if (close_o) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else if (idle && div_i) begin
      up_q  <= 1'b1;
      cnt_q <= CW'(1);
    end else if (idle && ref_i) begin
      dn_q  <= 1'b1;
      cnt_q <= CW'(1);
    end else if (!idle && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign lead_up_o = up_q;
  assign lead_dn_o = dn_q;
  assign err_cnt_o = cnt_q;

  // R1
  lag_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && ref_i) |=> (!up_q && !dn_q));
endmodule

// File: rtl/pump_shaper.sv
`timescale 1ns/1ps
module pump_shaper
  import phase_lock_pkg::*;
#(
  parameter int CW        = 4,
  parameter int DZC_CYC   = 2,
  parameter int DZD_CYC   = 4,
  parameter int MIN_A_CYC = 2,
  parameter int MIN_B_CYC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dz_mode_e      dz_mode_i,
  input  logic          lead_up_i,
  input  logic          lead_dn_i,
  input  logic [CW-1:0] err_cnt_i,
  input  logic          close_i,
  output logic          up_o,
  output logic          dn_o
);
  localparam int MIN_MAX = (MIN_A_CYC > MIN_B_CYC) ? MIN_A_CYC : MIN_B_CYC;
  localparam int MW      = $clog2(MIN_MAX + 1) < 1 ? 1 : $clog2(MIN_MAX + 1);
  localparam logic [CW-1:0] DZC_V = CW'(DZC_CYC);
  localparam logic [CW-1:0] DZD_V = CW'(DZD_CYC);
  localparam logic [MW-1:0] MNA_V = MW'(MIN_A_CYC);
  localparam logic [MW-1:0] MNB_V = MW'(MIN_B_CYC);

  logic          both_on;
  logic [CW-1:0] dz_thr;
  logic [MW-1:0] min_w;
  logic [MW-1:0] corr_q;
  logic          corr_act;

  assign both_on  = (dz_mode_i == DZ_A) || (dz_mode_i == DZ_B);
  assign dz_thr   = (dz_mode_i == DZ_C) ? DZC_V : DZD_V;
  assign min_w    = (dz_mode_i == DZ_A) ? MNA_V : MNB_V;
  assign corr_act = corr_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               corr_q <= '0;
    else if (close_i)          corr_q <= both_on ? min_w : '0;
    else if (corr_act)         corr_q <= corr_q - MW'(1);
  end

  always_comb begin
    if (both_on) begin
      up_o = lead_up_i || corr_act;
      dn_o = lead_dn_i || corr_act;
    end else begin
      up_o = lead_up_i && (err_cnt_i > dz_thr);
      dn_o = lead_dn_i && (err_cnt_i > dz_thr);
    end
  end

  // R2 (dead-zone counts are at least one cycle)
  dz_quiet_after_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_on && close_i) |=> (!up_o && !dn_o));
endmodule

// File: rtl/lock_monitor.sv
`timescale 1ns/1ps
module lock_monitor #(
  parameter int CW            = 4,
  parameter int UL_NARROW_CYC = 50,
  parameter int UL_WIDE_CYC   = 100,
  parameter int STRETCH_CYC   = 150000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    ul_sel_i,
  input  logic          lead_up_i,
  input  logic          lead_dn_i,
  input  logic [CW-1:0] err_cnt_i,
  output logic          unlocked_o
);
  localparam int TW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] NAR_V = CW'(UL_NARROW_CYC);
  localparam logic [CW-1:0] WID_V = CW'(UL_WIDE_CYC);
  localparam logic [TW-1:0] STR_V = TW'(STRETCH_CYC);

  logic          det_on;
  logic          over;
  logic [CW-1:0] thr;
  logic [TW-1:0] tmr_q;

  assign det_on = ul_sel_i != 2'b00;
  assign thr    = (ul_sel_i == 2'b01) ? NAR_V : WID_V;
  assign over   = det_on && (lead_up_i || lead_dn_i) && (err_cnt_i > thr);

  // retriggerable stretch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tmr_q <= '0;
    else if (!det_on)      tmr_q <= '0;
    else if (over)         tmr_q <= STR_V;
    else if (tmr_q != '0)  tmr_q <= tmr_q - TW'(1);
  end

  assign unlocked_o = tmr_q != '0;

  // R4
  ul_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ul_sel_i == 2'b00) |=> !unlocked_o);
  // R5
  ul_flag_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over |=> unlocked_o);
endmodule

// File: rtl/phase_lock_cmp.sv
`timescale 1ns/1ps
module phase_lock_cmp
  import phase_lock_pkg::*;
#(
  parameter int UL_NARROW_CYC = 50,
  parameter int UL_WIDE_CYC   = 100,
  parameter int STRETCH_CYC   = 150000,
  parameter int DZC_CYC       = 2,
  parameter int DZD_CYC       = 4,
  parameter int MIN_A_CYC     = 2,
  parameter int MIN_B_CYC     = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic       div_i,
  input  logic [1:0] dz_mode_i,
  input  logic [1:0] ul_sel_i,
  input  logic [1:0] sub_ctl_i,
  input  logic       force_low_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       sub_up_o,
  output logic       sub_dn_o,
  output logic       unlock_o
);
  localparam int MAX_UL = (UL_WIDE_CYC > UL_NARROW_CYC) ? UL_WIDE_CYC : UL_NARROW_CYC;
  localparam int MAX_DZ = (DZD_CYC > DZC_CYC) ? DZD_CYC : DZC_CYC;
  localparam int MAX_TH = (MAX_UL > MAX_DZ) ? MAX_UL : MAX_DZ;
  localparam int CW     = $clog2(MAX_TH + 2);

  logic          lead_up, lead_dn, close;
  logic [CW-1:0] err_cnt;
  logic          sh_up, sh_dn;
  logic          unlocked;
  logic          sub_act;

  phase_err_track #(.CW(CW)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_i     (ref_i),
    .div_i     (div_i),
    .lead_up_o (lead_up),
    .lead_dn_o (lead_dn),
    .err_cnt_o (err_cnt),
    .close_o   (close)
  );

  pump_shaper #(
    .CW(CW), .DZC_CYC(DZC_CYC), .DZD_CYC(DZD_CYC),
    .MIN_A_CYC(MIN_A_CYC), .MIN_B_CYC(MIN_B_CYC)
  ) u_shaper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dz_mode_i (dz_mode_e'(dz_mode_i)),
    .lead_up_i (lead_up),
    .lead_dn_i (lead_dn),
    .err_cnt_i (err_cnt),
    .close_i   (close),
    .up_o      (sh_up),
    .dn_o      (sh_dn)
  );

  lock_monitor #(
    .CW(CW), .UL_NARROW_CYC(UL_NARROW_CYC),
    .UL_WIDE_CYC(UL_WIDE_CYC), .STRETCH_CYC(STRETCH_CYC)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ul_sel_i   (ul_sel_i),
    .lead_up_i  (lead_up),
    .lead_dn_i  (lead_dn),
    .err_cnt_i  (err_cnt),
    .unlocked_o (unlocked)
  );

  assign sub_act = sub_ctl_i[1] && (sub_ctl_i[0] || unlocked);

  always_comb begin
    if (force_low_i) begin
      pump_up_o = 1'b0;
      pump_dn_o = 1'b1;
      sub_up_o  = 1'b0;
      sub_dn_o  = 1'b1;
    end else begin
      pump_up_o = sh_up;
      pump_dn_o = sh_dn;
      sub_up_o  = sub_act && sh_up;
      sub_dn_o  = sub_act && sh_dn;
    end
  end

  assign unlock_o = unlocked;

  // R7
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_i |-> (pump_dn_o && !pump_up_o && sub_dn_o && !sub_up_o));
endmodule

// File: tb/phase_lock_cmp_test.sv
`timescale 1ns/1ps
module phase_lock_cmp_test;
  localparam int NAR = 4, WID = 7, STR = 40, DZC = 2, DZD = 4, MNA = 2, MNB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0, div_p = 1'b0, force_low = 1'b0;
  logic [1:0] dz_mode = 2'b00, ul_sel = 2'b00, sub_ctl = 2'b00;
  logic pump_up, pump_dn, sub_up, sub_dn, unlock;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  phase_lock_cmp #(
    .UL_NARROW_CYC(NAR), .UL_WIDE_CYC(WID), .STRETCH_CYC(STR),
    .DZC_CYC(DZC), .DZD_CYC(DZD), .MIN_A_CYC(MNA), .MIN_B_CYC(MNB)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_p), .div_i(div_p),
    .dz_mode_i(dz_mode), .ul_sel_i(ul_sel), .sub_ctl_i(sub_ctl),
    .force_low_i(force_low), .pump_up_o(pump_up), .pump_dn_o(pump_dn),
    .sub_up_o(sub_up), .sub_dn_o(sub_dn), .unlock_o(unlock)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // side 0: divided pulse leads; side 1: reference leads
  task automatic run_pair(input int side, input int w, input int dz, input int ul, input int sc);
    int win, thr, mn, th;
    int a_up, a_dn, a_ul, a_su, a_sd, e_up, e_dn, e_ul, e_su, e_sd;
    bit lead_on, oth_on, unl, x_up, x_dn;
    win = w + STR + 12;
    mn  = (dz == 0) ? MNA : MNB;
    thr = (dz == 2) ? DZC : DZD;
    th  = (ul == 1) ? NAR : WID;
    a_up = 0; a_dn = 0; a_ul = 0; a_su = 0; a_sd = 0;
    e_up = 0; e_dn = 0; e_ul = 0; e_su = 0; e_sd = 0;
    for (int i = 0; i <= win; i++) begin
      @(negedge clk);
      if (i == 0) begin
        dz_mode = 2'(dz); ul_sel = 2'(ul); sub_ctl = 2'(sc);
      end else begin
        int t;
        t = i - 1;
        a_up += int'(pump_up); a_dn += int'(pump_dn); a_ul += int'(unlock);
        a_su += int'(sub_up);  a_sd += int'(sub_dn);
        if (dz < 2) begin
          lead_on = (t < w + mn);
          oth_on  = (t >= w) && (t < w + mn);
        end else begin
          lead_on = (t >= thr) && (t < w);
          oth_on  = 1'b0;
        end
        x_up = (side == 0) ? lead_on : oth_on;
        x_dn = (side == 0) ? oth_on : lead_on;
        unl  = (ul != 0) && (w > th) && (t >= th + 1) && (t <= w + STR - 1);
        e_up += int'(x_up); e_dn += int'(x_dn); e_ul += int'(unl);
        if (sc == 3 || (sc == 2 && unl)) begin
          e_su += int'(x_up); e_sd += int'(x_dn);
        end
      end
      if (w == 0) begin
        div_p = (i == 0); ref_p = (i == 0);
      end else if (side == 0) begin
        div_p = (i == 0); ref_p = (i == w);
      end else begin
        ref_p = (i == 0); div_p = (i == w);
      end
    end
    div_p = 1'b0; ref_p = 1'b0;
    if (dz < 2) begin
      chk($sformatf("R1/R3 up dz=%0d side=%0d w=%0d", dz, side, w), a_up, e_up);
      chk($sformatf("R1/R3 dn dz=%0d side=%0d w=%0d", dz, side, w), a_dn, e_dn);
    end else begin
      chk($sformatf("R1/R2 up dz=%0d side=%0d w=%0d", dz, side, w), a_up, e_up);
      chk($sformatf("R1/R2 dn dz=%0d side=%0d w=%0d", dz, side, w), a_dn, e_dn);
    end
    if (ul == 0 || w <= th)
      chk($sformatf("R4 unlock ul=%0d w=%0d", ul, w), a_ul, e_ul);
    else
      chk($sformatf("R5 unlock stretch ul=%0d w=%0d", ul, w), a_ul, e_ul);
    chk($sformatf("R6 sub_up sc=%0d w=%0d", sc, w), a_su, e_su);
    chk($sformatf("R6 sub_dn sc=%0d w=%0d", sc, w), a_sd, e_sd);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    chk("R8 reset pump_up", int'(pump_up), 0);
    chk("R8 reset pump_dn", int'(pump_dn), 0);
    chk("R8 reset sub", int'(sub_up | sub_dn), 0);
    chk("R8 reset unlock", int'(unlock), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int dz = 0; dz < 4; dz++)
      for (int side = 0; side < 2; side++)
        for (int w = 0; w <= 10; w++)
          run_pair(side, w, dz, (w + side + dz) % 4, (w * 3 + dz + side) % 4);

    // R6 forced combinations with a large error
    run_pair(0, 10, 0, 1, 2);
    run_pair(1, 9, 2, 2, 2);
    run_pair(0, 10, 3, 3, 3);
    run_pair(1, 10, 1, 1, 1);

    // R7
    @(negedge clk);
    dz_mode = 2'b00; sub_ctl = 2'b00; force_low = 1'b1; div_p = 1'b1;
    @(negedge clk);
    div_p = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 force pump_up", int'(pump_up), 0);
    chk("R7 force pump_dn", int'(pump_dn), 1);
    chk("R7 force sub_up", int'(sub_up), 0);
    chk("R7 force sub_dn", int'(sub_dn), 1);
    ref_p = 1'b1;
    @(negedge clk);
    ref_p = 1'b0; force_low = 1'b0;
    repeat (STR + 10) @(negedge clk);
    chk("R7 released pump idle", int'(pump_up | pump_dn), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule